// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 device from power-up to normal operation. After a start pulse it runs a fixed script of memory commands: a first NOP, a long settling wait, then precharges, writes to the extended and main mode registers, auto-refreshes and a final switch to normal mode. It presents each command on a command port with a valid/ready handshake. A downstream command path turns each accepted command into pin activity.

Once normal mode is entered, the block issues one dummy write. It then pulses a load strobe that hands the configured refresh interval to the refresh timer, and after that it reports done. Done stays high until the next reset. The block also computes, from static configuration inputs, the bit position at which the bank address sits in the system address. System software or an address mapper uses that position to reach the extended mode registers.

Top module: `ddr2_init_seq`

## Requirements
- R1: After synchronous reset, cmd_valid, busy, done and rfsh_load are all low.
- R2: A start pulse in the idle state begins the script: in the next cycle busy is high and cmd_valid is high with a NOP (code 0) on bank 0.
- R3: While cmd_valid is high and cmd_ready is low, the command fields stay unchanged. Each cycle in which cmd_valid and cmd_ready are both high advances the script by exactly one step.
- R4: After the first NOP is accepted, the next command's cmd_valid first rises exactly WAIT_CYC cycles after the accept cycle. WAIT_CYC is ceil(WAIT_US × CLK_HZ / 1e6), which is 50000 at the defaults.
- R5: The command codes follow this order: NOP, NOP, PREA, EMRS, EMRS, EMRS, MRS, PREA, REF, REF, MRS, EMRS, EMRS, NORMAL, DUMMY_WR. The encodings are NOP=0, PREA=1, MRS=2, EMRS=3, REF=4, NORMAL=5, DUMMY_WR=6.
- R6: The five extended-mode commands carry banks 2, 3, 1, 1, 1 in that order. Every other command carries bank 0.
- R7: cmd_dll_reset is high only on the first MRS. cmd_ocd_default is high only on the first of the last two EMRS commands. Both flags are low on every other command.
- R8: After DUMMY_WR is accepted, rfsh_load is high for exactly one cycle with rfsh_rate equal to cfg_refresh_rate. In the next cycle done goes high and busy goes low, and done then stays high until reset.
- R9: A start pulse while busy or done is ignored: the command stream and the status are unchanged.
- R10: ba_offset equals cfg_col_code + 9, plus (cfg_row_code + 11) when cfg_interleave is 0, plus 2 when cfg_bus32 is 1 or plus 1 when it is 0.
- R11: A synchronous reset mid-script returns the block to idle (no valid command, busy and done low). A later start runs the full script from the first NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for the bring-up script |
| cfg_col_code | input | COL_W | Column-bits code |
| cfg_row_code | input | ROW_W | Row-bits code |
| cfg_interleave | input | 1 | 1 = bank-interleaved address decoding |
| cfg_bus32 | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| cfg_refresh_rate | input | RFSH_W | Refresh interval handed to the refresh timer |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command accepted by the command path |
| cmd_code | output | 3 | Command code (see R5) |
| cmd_bank | output | 3 | Bank address of the command |
| cmd_dll_reset | output | 1 | DLL-reset bit for a mode-register write |
| cmd_ocd_default | output | 1 | OCD-default bit for an extended-mode write |
| ba_offset | output | OFF_W | Bit position of the bank address in the system address |
| busy | output | 1 | Script running |
| done | output | 1 | Initialization complete (sticky) |
| rfsh_load | output | 1 | One-cycle load strobe for the refresh timer |
| rfsh_rate | output | RFSH_W | Refresh interval to load |

## Verification
The bench stalls cmd_ready at random. A sequencer that advanced on valid alone, or that skipped a step, would then fall out of order against the reference script. It measures the gap from the first NOP's acceptance to the next command, so an off-by-one in the wait timer shows up as a gap of WAIT_CYC±1. Start pulses sent during the wait and after completion would restart the script, or drop done, in a design that failed to guard them. A reset in the middle of the wait, followed by a fresh start, exposes any step or timer state that survives reset. A sweep over every configuration code catches a wrong base constant, or an interleave or bus-width term added the wrong way round, in the bank-offset arithmetic.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_PREA     = 3'd1,
        CMD_MRS      = 3'd2,
        CMD_EMRS     = 3'd3,
        CMD_REF      = 3'd4,
        CMD_NORMAL   = 3'd5,
        CMD_DUMMY_WR = 3'd6
    } cmd_e;

    typedef struct packed {
        cmd_e       code;
        logic [2:0] bank;
        logic       dll;
        logic       ocd;
    } cmd_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ISSUE,
        PH_WAIT,
        PH_LOAD,
        PH_DONE
    } phase_e;

    localparam int NUM_STEPS = 15;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int COL_BASE  = 9;
    localparam int ROW_BASE  = 11;

endpackage

// File: rtl/ddr2_ba_offset.sv
module ddr2_ba_offset #(
    parameter int COL_W = 2,
    parameter int ROW_W = 2,
    parameter int OFF_W = 5
) (
    input  logic [COL_W-1:0] col_code,
    input  logic [ROW_W-1:0] row_code,
    input  logic             interleave,
    input  logic             bus32,
    output logic [OFF_W-1:0] offset
);
    import ddr2_init_pkg::*;

    logic [OFF_W-1:0] col_part;
    logic [OFF_W-1:0] row_part;
    logic [OFF_W-1:0] bus_part;

    always_comb begin
        col_part = OFF_W'(col_code) + OFF_W'(COL_BASE);
        row_part = interleave ? '0 : (OFF_W'(row_code) + OFF_W'(ROW_BASE));
        bus_part = bus32 ? OFF_W'(2) : OFF_W'(1);
        offset   = col_part + row_part + bus_part;
    end

endmodule

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
    parameter int WAIT_CYC = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic expire
);
    localparam int CNT_W = $clog2(WAIT_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 2);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expire = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (!expire) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ddr2_init_script.sv
module ddr2_init_script
    import ddr2_init_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output cmd_t              cmd
);

    always_comb begin
        cmd = '{code: CMD_NOP, bank: 3'd0, dll: 1'b0, ocd: 1'b0};
        case (step)
            4'd0:  cmd.code = CMD_NOP;
            4'd1:  cmd.code = CMD_NOP;
            4'd2:  cmd.code = CMD_PREA;
            4'd3:  begin cmd.code = CMD_EMRS; cmd.bank = 3'd2; end
            4'd4:  begin cmd.code = CMD_EMRS; cmd.bank = 3'd3; end
            4'd5:  begin cmd.code = CMD_EMRS; cmd.bank = 3'd1; end
            4'd6:  begin cmd.code = CMD_MRS;  cmd.dll  = 1'b1; end
            4'd7:  cmd.code = CMD_PREA;
            4'd8:  cmd.code = CMD_REF;
            4'd9:  cmd.code = CMD_REF;
            4'd10: cmd.code = CMD_MRS;
            4'd11: begin cmd.code = CMD_EMRS; cmd.bank = 3'd1; cmd.ocd = 1'b1; end
            4'd12: begin cmd.code = CMD_EMRS; cmd.bank = 3'd1; end
            4'd13: cmd.code = CMD_NORMAL;
            4'd14: cmd.code = CMD_DUMMY_WR;
            default: cmd.code = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int CLK_HZ  = 250_000_000,
    parameter int WAIT_US = 200,
    parameter int COL_W   = 2,
    parameter int ROW_W   = 2,
    parameter int RFSH_W  = 12,
    parameter int OFF_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [COL_W-1:0]  cfg_col_code,
    input  logic [ROW_W-1:0]  cfg_row_code,
    input  logic              cfg_interleave,
    input  logic              cfg_bus32,
    input  logic [RFSH_W-1:0] cfg_refresh_rate,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [2:0]        cmd_code,
    output logic [2:0]        cmd_bank,
    output logic              cmd_dll_reset,
    output logic              cmd_ocd_default,
    output logic [OFF_W-1:0]  ba_offset,
    output logic              busy,
    output logic              done,
    output logic              rfsh_load,
    output logic [RFSH_W-1:0] rfsh_rate
);
    localparam longint unsigned WAIT_PROD = longint'(WAIT_US) * longint'(CLK_HZ);
    localparam int WAIT_CYC = int'((WAIT_PROD + 64'd999_999) / 64'd1_000_000);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        phase_e             phase;
        logic [STEP_W-1:0]  step;
    } seq_t;

    seq_t s_d, s_q;
    cmd_t cur_cmd;
    logic wait_expire;

    ddr2_init_script u_script (
        .step (s_q.step),
        .cmd  (cur_cmd)
    );

    ddr2_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (s_q.phase != PH_WAIT),
        .expire (wait_expire)
    );

    ddr2_ba_offset #(.COL_W(COL_W), .ROW_W(ROW_W), .OFF_W(OFF_W)) u_ba (
        .col_code   (cfg_col_code),
        .row_code   (cfg_row_code),
        .interleave (cfg_interleave),
        .bus32      (cfg_bus32),
        .offset     (ba_offset)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_ISSUE;
                    s_d.step  = '0;
                end
            end
            PH_ISSUE: begin
                if (cmd_ready) begin
                    if (s_q.step == '0) begin
                        s_d.phase = PH_WAIT;
                    end else if (s_q.step == LAST_STEP) begin
                        s_d.phase = PH_LOAD;
                    end else begin
                        s_d.step = s_q.step + 1'b1;
                    end
                end
            end
            PH_WAIT: begin
                if (wait_expire) begin
                    s_d.phase = PH_ISSUE;
                    s_d.step  = STEP_W'(1);
                end
            end
            PH_LOAD: s_d.phase = PH_DONE;
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{phase: PH_IDLE, step: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_valid       = (s_q.phase == PH_ISSUE);
    assign cmd_code        = cur_cmd.code;
    assign cmd_bank        = cur_cmd.bank;
    assign cmd_dll_reset   = cmd_valid & cur_cmd.dll;
    assign cmd_ocd_default = cmd_valid & cur_cmd.ocd;
    assign busy            = (s_q.phase == PH_ISSUE) || (s_q.phase == PH_WAIT)
                          || (s_q.phase == PH_LOAD);
    assign done            = (s_q.phase == PH_DONE);
    assign rfsh_load       = (s_q.phase == PH_LOAD);
    assign rfsh_rate       = cfg_refresh_rate;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
    parameter int OFF_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_code,
    input logic [2:0]       cmd_bank,
    input logic             cmd_dll_reset,
    input logic             cmd_ocd_default,
    input logic [OFF_W-1:0] ba_offset,
    input logic             busy,
    input logic             done,
    input logic             rfsh_load
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cmd_valid && !busy && !done && !rfsh_load));

    p_valid_busy_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_bank)
                                       && $stable(cmd_dll_reset) && $stable(cmd_ocd_default)));

    p_dll_on_mrs_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_dll_reset |-> (cmd_valid && cmd_code == 3'd2 && cmd_bank == 3'd0));

    p_ocd_on_emrs1_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_ocd_default |-> (cmd_valid && cmd_code == 3'd3 && cmd_bank == 3'd1));

    p_load_then_done_r8: assert property (@(posedge clk) disable iff (rst)
        rfsh_load |=> (done && !rfsh_load));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !cmd_valid));

    p_offset_range_r10: assert property (@(posedge clk) disable iff (rst)
        (ba_offset >= OFF_W'(10)) && (ba_offset <= OFF_W'(28)));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.OFF_W(OFF_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmd_valid       (cmd_valid),
    .cmd_ready       (cmd_ready),
    .cmd_code        (cmd_code),
    .cmd_bank        (cmd_bank),
    .cmd_dll_reset   (cmd_dll_reset),
    .cmd_ocd_default (cmd_ocd_default),
    .ba_offset       (ba_offset),
    .busy            (busy),
    .done            (done),
    .rfsh_load       (rfsh_load)
);

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;

    localparam int W = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  cfg_col_code = 2'd1;
    logic [1:0]  cfg_row_code = 2'd2;
    logic        cfg_interleave = 1'b0;
    logic        cfg_bus32 = 1'b1;
    logic [11:0] cfg_refresh_rate = 12'h3A5;
    logic        cmd_ready = 1'b1;
    logic        cmd_valid, cmd_dll_reset, cmd_ocd_default, busy, done, rfsh_load;
    logic [2:0]  cmd_code, cmd_bank;
    logic [4:0]  ba_offset;
    logic [11:0] rfsh_rate;

    int ncmp = 0, nerr = 0, cyc = 0;
    bit stall_mode = 0, started = 0, finished = 0;

    // reference model state
    int mph = 0, midx = 0, mcnt = 0;
    int t_acc = 0; bit armed = 0;
    int exp_code [15] = '{0,0,1,3,3,3,2,1,4,4,2,3,3,5,6};
    int exp_bank [15] = '{0,0,0,2,3,1,0,0,0,0,0,1,1,0,0};
    int exp_dll  [15] = '{0,0,0,0,0,0,1,0,0,0,0,0,0,0,0};
    int exp_ocd  [15] = '{0,0,0,0,0,0,0,0,0,0,0,1,0,0,0};

    ddr2_init_seq u_dut (.*);

    always #2 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        ncmp++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int ref_off(int col, int row, bit il, bit b32);
        return col + 9 + (il ? 0 : row + 11) + (b32 ? 2 : 1);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
            $finish;
        end
    endtask

    // reference model, advanced on the same edge as the design
    always @(posedge clk) begin
        started = 1;
        cyc++;
        if (rst) begin
            mph = 0; midx = 0; mcnt = 0;
        end else begin
            case (mph)
                0: if (start) begin mph = 1; midx = 0; end
                1: if (cmd_ready) begin
                       if (midx == 0) begin mph = 2; mcnt = 0; end
                       else if (midx == 14) mph = 3;
                       else midx++;
                   end
                2: begin
                       mcnt++;
                       if (mcnt == W - 1) begin mph = 1; midx = 1; end
                   end
                3: mph = 4;
                default: mph = 4;
            endcase
        end
        if (cyc > 180000) begin
            nerr++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 180000);
            finish_run();
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("R3 cmd_valid", int'(cmd_valid), int'(mph == 1));
            chk("R2 busy", int'(busy), int'(mph >= 1 && mph <= 3));
            chk("R8 done", int'(done), int'(mph == 4));
            chk("R8 rfsh_load", int'(rfsh_load), int'(mph == 3));
            chk("R10 ba_offset", int'(ba_offset),
                ref_off(int'(cfg_col_code), int'(cfg_row_code), cfg_interleave, cfg_bus32));
            if (mph == 1) begin
                chk("R5 cmd_code", int'(cmd_code), exp_code[midx]);
                chk("R6 cmd_bank", int'(cmd_bank), exp_bank[midx]);
                chk("R7 dll_reset", int'(cmd_dll_reset), exp_dll[midx]);
                chk("R7 ocd_default", int'(cmd_ocd_default), exp_ocd[midx]);
                if (midx == 1 && armed) begin
                    chk("R4 wait gap", cyc - t_acc, W);
                    armed = 0;
                end
                if (midx == 0 && cmd_valid && cmd_ready && !rst) begin
                    t_acc = cyc; armed = 1;
                end
            end
            if (mph == 3)
                chk("R8 rfsh_rate", int'(rfsh_rate), int'(cfg_refresh_rate));
            if (rst) armed = 0;
        end
    end

    // ready driver
    always @(negedge clk) begin
        #1;
        cmd_ready <= stall_mode ? 1'($urandom_range(0, 1)) : 1'b1;
    end

    task automatic cyc_step(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic pulse_start();
        start = 1'b1; cyc_step(1); start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) cyc_step(1);
    endtask

    initial begin
        cyc_step(4);
        rst = 1'b0;
        cyc_step(1);
        @(negedge clk);
        // R1: reset state
        chk("R1 valid after reset", int'(cmd_valid), 0);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);
        #1;

        // run 1: always ready, start pulses during the wait and after done
        pulse_start();
        @(negedge clk);
        chk("R2 first cmd NOP", int'(cmd_code), 0);
        #1;
        cyc_step(20);
        pulse_start();                       // R9: start while busy
        @(negedge clk);
        chk("R9 start ignored busy", int'(cmd_valid), 0);
        #1;
        wait_done();
        cyc_step(3);
        pulse_start();                       // R9: start after done
        cyc_step(2);
        @(negedge clk);
        chk("R9 start ignored done", int'(done), 1);
        chk("R9 no cmd after done", int'(cmd_valid), 0);
        #1;

        // R10: sweep every configuration code
        for (int k = 0; k < 64; k++) begin
            cfg_col_code   = 2'(k);
            cfg_row_code   = 2'(k >> 2);
            cfg_interleave = k[4];
            cfg_bus32      = k[5];
            cyc_step(1);
        end

        // run 2: stalls, reset in the middle of the wait
        rst = 1'b1; cyc_step(2); rst = 1'b0;
        cfg_col_code = 2'd3; cfg_row_code = 2'd1; cfg_interleave = 1'b1; cfg_bus32 = 1'b0;
        cfg_refresh_rate = 12'h0C7;
        stall_mode = 1;
        pulse_start();
        cyc_step(200);
        rst = 1'b1; cyc_step(1); rst = 1'b0;
        @(negedge clk);
        chk("R11 idle after mid reset", int'(busy), 0);
        chk("R11 no valid after mid reset", int'(cmd_valid), 0);
        chk("R11 done low after mid reset", int'(done), 0);
        #1;
        pulse_start();
        wait_done();
        cyc_step(5);
        chk("R8 done held", int'(done), 1);
        finish_run();
    end

endmodule